// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns a digitized supply-status bit and a watchdog-expiry strobe into the system reset signals of a chip. When the supply flag reports a low supply, the active-low reset, its active-high twin and a low-line status flag all change in the same cycle, with no clock edge in between. A gated chip-enable output is also forced inactive in that cycle. Once the supply is back, reset is held for a set number of timebase ticks before it releases. A watchdog expiry starts a reset pulse of the same length, and both cases use one hold counter.

The hold is timed by counting ticks, not clock cycles. A select input picks one of two tick sources: an internal-oscillator tick or an external-clock tick. Each source has its own hold length, given as a parameter. After the synchronous block reset, reset starts asserted and a full hold must run out before it releases. Analog comparison, battery switching and pad drive are outside this block.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_low` is 1, `reset_n_out` is 0 in the same cycle, with no clock edge needed. This holds whatever the watchdog strobe or the ticks are doing.
- R2: After `supply_low` falls, `reset_n_out` stays 0 until the selected tick source has pulsed the hold length of that source. It goes to 1 at the clock edge that samples the final tick.
- R3: A `wdog_expire` pulse sampled while `supply_low` is 0 drives `reset_n_out` to 0 from the next clock edge. The pulse then lasts the same number of ticks as a supply-recovery hold.
- R4: `reset_out` is always the exact inverse of `reset_n_out`.
- R5: `lowline_n` equals the inverse of `supply_low` in the same cycle, with no hold.
- R6: `ce_out_n` equals `ce_in_n` while `supply_low` is 0, and is 1 (inactive) while `supply_low` is 1.
- R7: With `tb_sel` = 1, only `tick_int` pulses are counted and the hold length is `HOLD_INT`. With `tb_sel` = 0, only `tick_ext` pulses are counted and the hold length is `HOLD_EXT`. Pulses on the source that is not selected have no effect.
- R8: If `supply_low` returns to 1 during a hold, the tick count restarts from zero.
- R9: A `wdog_expire` pulse that arrives while reset is already asserted restarts the tick count from zero and changes nothing else.
- R10: While `rst_n` is low, and after it is released, reset is asserted. A full hold of the selected source must then elapse before `reset_n_out` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset (power-on) |
| supply_low | input | 1 | Digitized supply-below-threshold flag, synchronous to clk |
| wdog_expire | input | 1 | One-cycle strobe from an enabled watchdog that has expired |
| tb_sel | input | 1 | Timebase select: 1 = internal tick, 0 = external tick |
| tick_int | input | 1 | One-cycle tick from the internal-oscillator divider |
| tick_ext | input | 1 | One-cycle tick derived from the external clock |
| ce_in_n | input | 1 | Active-low chip-enable request |
| reset_n_out | output | 1 | Active-low system reset |
| reset_out | output | 1 | Active-high system reset |
| lowline_n | output | 1 | Active-low immediate low-supply status |
| ce_out_n | output | 1 | Gated active-low chip enable |

## Verification
The assertions take for granted that `supply_low`, `wdog_expire` and both tick inputs are already synchronous to `clk` and only change between rising edges. They also assume every hold length is at least one tick, so a recovery is always followed by at least one asserted cycle. The stimulus changes every input only on the falling clock edge, keeps both hold lengths small but non-zero, and switches `tb_sel` only while no hold is running.

// File: rtl/supv_pkg.sv
// Package: shared type and helper for the supervisory reset block.
// Assumes: nothing beyond standard SystemVerilog.
package supv_pkg;
    // Timebase source encoding as seen on the select input.
    typedef enum logic {
        TB_EXTERNAL = 1'b0,
        TB_INTERNAL = 1'b1
    } tb_src_e;

    // Larger of two integers, used to size the shared hold counter.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/supv_tick_sel.sv
// Module: supv_tick_sel
// Chooses which tick stream times the reset hold, and which hold length goes with it.
// Assumes: both tick inputs are single-cycle pulses synchronous to the block clock.
module supv_tick_sel
    import supv_pkg::*;
#(
    parameter int HOLD_INT = 50,
    parameter int HOLD_EXT = 20,
    parameter int CNT_W    = 6
) (
    input  logic             tb_sel,
    input  logic             tick_int,
    input  logic             tick_ext,
    output logic             tick,
    output logic [CNT_W-1:0] hold_len
);
    tb_src_e src;

    // Select the active tick source and its matching hold length.
    always_comb begin
        src = tb_src_e'(tb_sel);
        if (src == TB_INTERNAL) begin
            tick     = tick_int;
            hold_len = CNT_W'(HOLD_INT);
        end else begin
            tick     = tick_ext;
            hold_len = CNT_W'(HOLD_EXT);
        end
    end
endmodule

// File: rtl/supv_hold_ctr.sv
// Module: supv_hold_ctr
// The one hold counter used both for supply-recovery release and for watchdog reset pulses.
// A low supply or a watchdog strobe (re)arms it. Selected ticks advance it. It clears the
// hold flag at the edge that samples the final tick.
// Assumes: hold_len >= 1; inputs are synchronous to clk.
module supv_hold_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_low,
    input  logic             wdog_expire,
    input  logic             tick,
    input  logic [CNT_W-1:0] hold_len,
    output logic             hold_active
);
    logic [CNT_W-1:0] tick_cnt;

    // Arm, count and release the reset hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_active <= 1'b1;
            tick_cnt    <= '0;
        end else if (supply_low || wdog_expire) begin
            hold_active <= 1'b1;
            tick_cnt    <= '0;
        end else if (hold_active && tick) begin
            if (tick_cnt >= hold_len - CNT_W'(1)) begin
                hold_active <= 1'b0;
                tick_cnt    <= '0;
            end else begin
                tick_cnt <= tick_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/supv_out_gate.sv
// Module: supv_out_gate
// Combinational output stage: reset pair, low-line flag and chip-enable gating.
// The supply flag acts here with no register, so a low supply shows at once.
// Assumes: hold_active comes from the hold counter.
module supv_out_gate (
    input  logic supply_low,
    input  logic hold_active,
    input  logic ce_in_n,
    output logic reset_n_out,
    output logic reset_out,
    output logic lowline_n,
    output logic ce_out_n
);
    logic rst_req;

    // Form the reset request and drive all four outputs from it and the supply flag.
    always_comb begin
        rst_req     = supply_low | hold_active;
        reset_out   = rst_req;
        reset_n_out = ~rst_req;
        lowline_n   = ~supply_low;
        ce_out_n    = supply_low ? 1'b1 : ce_in_n;
    end
endmodule

// File: rtl/supv_reset_gen.sv
// Module: supv_reset_gen (top)
// Supervisory reset pulse generator: low-supply reset with a programmable hold,
// watchdog-triggered pulses of the same width, low-line status and chip-enable gating.
// Assumes: rst_n is a synchronous active-low power-on reset; HOLD_INT and HOLD_EXT >= 1.
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int HOLD_INT = 50,
    parameter int HOLD_EXT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic wdog_expire,
    input  logic tb_sel,
    input  logic tick_int,
    input  logic tick_ext,
    input  logic ce_in_n,
    output logic reset_n_out,
    output logic reset_out,
    output logic lowline_n,
    output logic ce_out_n
);
    localparam int HOLD_MAX = max_int(HOLD_INT, HOLD_EXT);
    localparam int CNT_W    = $clog2(HOLD_MAX + 1);

    logic             tick;
    logic [CNT_W-1:0] hold_len;
    logic             hold_active;

    supv_tick_sel #(
        .HOLD_INT (HOLD_INT),
        .HOLD_EXT (HOLD_EXT),
        .CNT_W    (CNT_W)
    ) u_tick_sel (
        .tb_sel   (tb_sel),
        .tick_int (tick_int),
        .tick_ext (tick_ext),
        .tick     (tick),
        .hold_len (hold_len)
    );

    supv_hold_ctr #(
        .CNT_W (CNT_W)
    ) u_hold_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_low  (supply_low),
        .wdog_expire (wdog_expire),
        .tick        (tick),
        .hold_len    (hold_len),
        .hold_active (hold_active)
    );

    supv_out_gate u_out_gate (
        .supply_low  (supply_low),
        .hold_active (hold_active),
        .ce_in_n     (ce_in_n),
        .reset_n_out (reset_n_out),
        .reset_out   (reset_out),
        .lowline_n   (lowline_n),
        .ce_out_n    (ce_out_n)
    );
endmodule

// File: rtl/supv_reset_gen_chk.sv
// Module: supv_reset_gen_chk
// Port-level properties of the supervisory reset generator, bound to the top module.
// Assumes: inputs change only between rising clock edges.
module supv_reset_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_low,
    input logic wdog_expire,
    input logic tb_sel,
    input logic tick_int,
    input logic tick_ext,
    input logic ce_in_n,
    input logic reset_n_out,
    input logic reset_out,
    input logic lowline_n,
    input logic ce_out_n
);
    // Low supply forces reset low.
    assert_low_supply_resets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !reset_n_out);

    // Reset is still held in the first cycle after the supply recovers.
    assert_hold_after_recovery_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_low) |-> !reset_n_out);

    // A watchdog strobe asserts reset from the next edge.
    assert_wdog_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_expire && !supply_low) |=> !reset_n_out);

    // Reset pair stays complementary.
    assert_reset_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out != reset_n_out);

    // Reset releases only while the low-line flag shows a good supply, also in the prior cycle.
    assert_release_good_supply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_n_out) |-> (lowline_n && $past(lowline_n)));

    // Chip enable is inactive while the supply is low.
    assert_ce_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> ce_out_n);

    // Release happens only right after a tick from the selected source.
    assert_release_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_n_out) |-> $past(tb_sel ? tick_int : tick_ext));

    // Reset is asserted right after the block reset is released.
    assert_power_on_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !reset_n_out);
endmodule

bind supv_reset_gen supv_reset_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_low  (supply_low),
    .wdog_expire (wdog_expire),
    .tb_sel      (tb_sel),
    .tick_int    (tick_int),
    .tick_ext    (tick_ext),
    .ce_in_n     (ce_in_n),
    .reset_n_out (reset_n_out),
    .reset_out   (reset_out),
    .lowline_n   (lowline_n),
    .ce_out_n    (ce_out_n)
);

// File: tb/supv_reset_gen_test.sv
// Bench for supv_reset_gen. A behavioural reference model runs alongside the design
// and every output is compared on every clock.
module supv_reset_gen_test;
    localparam int HI = 6;   // internal-tick hold length
    localparam int HE = 4;   // external-tick hold length

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0;
    logic wdog_expire = 1'b0;
    logic tb_sel = 1'b1;
    logic tick_int = 1'b0;
    logic tick_ext = 1'b0;
    logic ce_in_n = 1'b1;
    logic reset_n_out, reset_out, lowline_n, ce_out_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    string tag = "R10";

    // Reference model state: hold in progress and ticks counted so far.
    bit ref_busy = 1'b1;
    int ref_ticks = 0;

    always #5 clk = ~clk;

    supv_reset_gen #(.HOLD_INT(HI), .HOLD_EXT(HE)) uut (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .wdog_expire(wdog_expire),
        .tb_sel(tb_sel), .tick_int(tick_int), .tick_ext(tick_ext), .ce_in_n(ce_in_n),
        .reset_n_out(reset_n_out), .reset_out(reset_out), .lowline_n(lowline_n),
        .ce_out_n(ce_out_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    // One clock: drive inputs after the falling edge, compare, then advance the model.
    task automatic step(input bit sl, input bit wd);
        bit tk;
        int hl;
        supply_low  = sl;
        wdog_expire = wd;
        tick_int    = (cyc % 3 == 2);
        tick_ext    = (cyc % 2 == 1);
        ce_in_n     = cyc[2];
        #2;
        if (rst_n) begin
            check(tag,  reset_n_out, !(sl || ref_busy));
            check("R4", reset_out,   (sl || ref_busy));
            check("R5", lowline_n,   !sl);
            check("R6", ce_out_n,    sl ? 1'b1 : ce_in_n);
        end
        tk = tb_sel ? tick_int : tick_ext;   // R7: only the selected source counts
        hl = tb_sel ? HI : HE;
        @(posedge clk);
        if (!rst_n || sl || wd) begin
            ref_busy  = 1'b1;
            ref_ticks = 0;
        end else if (ref_busy && tk) begin
            ref_ticks++;
            if (ref_ticks >= hl) begin
                ref_busy  = 1'b0;
                ref_ticks = 0;
            end
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic run(input int n, input bit sl, input bit wd);
        for (int i = 0; i < n; i++) step(sl, wd);
    endtask

    initial begin
        @(negedge clk);
        // R10: block reset, then a full hold before release
        run(3, 1'b0, 1'b0);
        rst_n = 1'b1;
        #2;
        total++;
        if (reset_n_out !== 1'b0) begin
            bad++;
            $display("FAIL R10 reset state: actual=%b expected=0", reset_n_out);
        end
        run(25, 1'b0, 1'b0);
        // R1 and R2: supply dip and recovery hold
        tag = "R1";  run(4, 1'b1, 1'b0);
        tag = "R2";  run(25, 1'b0, 1'b0);
        // R8: second dip in the middle of a hold restarts it
        tag = "R8";  run(3, 1'b1, 1'b0); run(8, 1'b0, 1'b0);
        run(2, 1'b1, 1'b0); run(25, 1'b0, 1'b0);
        // R3: watchdog pulse of the same width
        tag = "R3";  step(1'b0, 1'b1); run(25, 1'b0, 1'b0);
        // R9: second strobe during a pulse restarts the count
        tag = "R9";  step(1'b0, 1'b1); run(6, 1'b0, 1'b0);
        step(1'b0, 1'b1); run(25, 1'b0, 1'b0);
        // R7: external timebase, supply dip then watchdog
        tb_sel = 1'b0;
        tag = "R7";  run(2, 1'b1, 1'b0); run(20, 1'b0, 1'b0);
        step(1'b0, 1'b1); run(20, 1'b0, 1'b0);
        // R1: strobe while supply is low keeps reset low
        tag = "R1";  step(1'b1, 1'b1); run(2, 1'b1, 1'b0);
        tag = "R7";  run(20, 1'b0, 1'b0);
        // R10: block reset in mid-operation, internal timebase again
        tb_sel = 1'b1;
        tag = "R10"; rst_n = 1'b0; run(2, 1'b0, 1'b0);
        rst_n = 1'b1; run(25, 1'b0, 1'b0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule